// File: doc/BRIEF.md
# Raster Operation Word Datapath

This block computes one destination word for a bit-block transfer engine. Source words arrive through a load strobe into a two-word shift buffer. A 4-bit skew picks a 16-bit window out of that buffer, so source data lines up with the destination when their bit positions differ. The window is mixed with a row of a built-in 16x16 halftone pattern under a 2-bit rule. The result is then combined with the old destination word under any of the sixteen two-input boolean functions. A per-bit mask decides which destination bits take the new value and which keep the old one.

The halftone row comes either from a line index that the caller supplies, or, in smudge mode, from the low bits of the skewed source word itself. A separate address port writes and reads the pattern store while the engine is idle. The block also tells the caller whether the old destination word affects the result, so a destination read can be skipped when it does not. Address generation and bus scheduling belong to the surrounding engine.

Top module: `rop_word_path`

## Requirements
- R1: After reset the source buffer and every halftone row are zero, so with skew 0, halftone rule 2, combine code 3 and mask 16'hFFFF, `dst_out` is 0 and `ht_rdata` is 0 at every address.
- R2: On a clock edge with `src_load`=1 and `src_rtl`=0, the buffer's lower 16 bits move to its upper 16 bits and `src_word` enters the lower 16 bits.
- R3: On a clock edge with `src_load`=1 and `src_rtl`=1, the buffer's upper 16 bits move to its lower 16 bits and `src_word` enters the upper 16 bits.
- R4: On a clock edge with `src_shift`=1 and `src_load`=0, the half-to-half move of R2 (or of R3 when `src_rtl`=1) still happens while the half that would have received new data keeps its value; `src_load` takes precedence over `src_shift`, and with neither set the buffer holds.
- R5: The working source word is buffer bits [skew+15 : skew], where buffer bit 31 is the most significant bit of the upper half.
- R6: The halftone rule selects the mixed word: 0 gives all ones, 1 the halftone row, 2 the working source word, 3 the bitwise AND of source and halftone row.
- R7: A write with `ht_we`=1 stores `ht_wdata` in row `ht_addr` at the clock edge; `ht_rdata` always shows the row at `ht_addr` without a clock.
- R8: With `smudge`=0 the halftone row is chosen by `line_idx`; with `smudge`=1 it is chosen by bits [3:0] of the working source word.
- R9: Each result bit is bit {~m,~d} of `rop_code`, where m is the mixed bit and d the destination bit: bit 0 for m=1,d=1, bit 1 for m=1,d=0, bit 2 for m=0,d=1, bit 3 for m=0,d=0 (code 0 is zero, 3 is the mixed word, 6 is XOR, F is ones).
- R10: Each `dst_out` bit equals the result bit where `dst_mask` is 1 and the `dst_in` bit where `dst_mask` is 0.
- R11: `dst_needed` is 1 exactly when `dst_mask` is not all ones or `rop_code` gives a different output for d=0 and d=1 at some value of m.
- R12: `dst_out`, `dst_needed` and `ht_rdata` follow their inputs in the same cycle; buffer loads and pattern writes take effect only from the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, synchronous |
| src_load | input | 1 | Shift a new source word into the buffer |
| src_shift | input | 1 | Move one buffer half to the other without new data |
| src_rtl | input | 1 | Source scanned right to left (mirrors the shift) |
| src_word | input | 16 | New source word |
| skew | input | 4 | Right shift applied to the buffer before the window is taken |
| ht_rule | input | 2 | Source/halftone mixing rule |
| rop_code | input | 4 | Boolean truth table for mixed word versus destination |
| smudge | input | 1 | Halftone row taken from the working source word |
| line_idx | input | 4 | Halftone row for the current line |
| dst_in | input | 16 | Old destination word |
| dst_mask | input | 16 | Per-bit write mask |
| ht_we | input | 1 | Halftone store write enable |
| ht_addr | input | 4 | Halftone store access row |
| ht_wdata | input | 16 | Halftone store write data |
| ht_rdata | output | 16 | Halftone store read data at `ht_addr` |
| dst_out | output | 16 | New destination word |
| dst_needed | output | 1 | Old destination word affects `dst_out` |

## Verification
Every output is combinational from the inputs and the stored state, so `dst_out`, `dst_needed` and `ht_rdata` are due in the same cycle their inputs change, while a buffer load, a bare shift or a pattern write becomes visible only after the following rising edge. The bench drives all inputs on the falling edge, checks the three outputs one nanosecond later against a model whose buffer and pattern store are updated only once the rising edge has passed, and so every check sees exactly the state one edge after the previous stimulus. Directed steps cover each buffer direction, the suppressed-read shift, skews 0, 4 and 15, every halftone rule, smudge, several combine codes and the mask extremes, and a long random run mixes all of them.

// File: rtl/rop_word_path.sv
module rop_word_path #(
  parameter int WORD_W  = 16,
  parameter int HT_ROWS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_load,
  input  logic                       src_shift,
  input  logic                       src_rtl,
  input  logic [WORD_W-1:0]          src_word,
  input  logic [$clog2(WORD_W)-1:0]  skew,
  input  logic [1:0]                 ht_rule,
  input  logic [3:0]                 rop_code,
  input  logic                       smudge,
  input  logic [$clog2(HT_ROWS)-1:0] line_idx,
  input  logic [WORD_W-1:0]          dst_in,
  input  logic [WORD_W-1:0]          dst_mask,
  input  logic                       ht_we,
  input  logic [$clog2(HT_ROWS)-1:0] ht_addr,
  input  logic [WORD_W-1:0]          ht_wdata,
  output logic [WORD_W-1:0]          ht_rdata,
  output logic [WORD_W-1:0]          dst_out,
  output logic                       dst_needed
);
  localparam int BUF_W = 2 * WORD_W;
  localparam int ROW_W = $clog2(HT_ROWS);

  logic [BUF_W-1:0]  src_buf;
  logic [WORD_W-1:0] ht_mem [HT_ROWS];
  logic [BUF_W-1:0]  shifted;
  logic [WORD_W-1:0] work_src, ht_word, mixed, result;
  logic [ROW_W-1:0]  ht_row;

  // Two-word source buffer; direction mirrors the half-to-half move.
  always_ff @(posedge clk) begin
    if (!rst_n)
      src_buf <= '0;
    else if (src_load)
      src_buf <= src_rtl ? {src_word, src_buf[BUF_W-1:WORD_W]}
                         : {src_buf[WORD_W-1:0], src_word};
    else if (src_shift)
      src_buf <= src_rtl ? {src_buf[BUF_W-1:WORD_W], src_buf[BUF_W-1:WORD_W]}
                         : {src_buf[WORD_W-1:0], src_buf[WORD_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HT_ROWS; i++) ht_mem[i] <= '0;
    end else if (ht_we) begin
      ht_mem[ht_addr] <= ht_wdata;
    end
  end

  assign ht_rdata = ht_mem[ht_addr];
  assign shifted  = src_buf >> skew;
  assign work_src = shifted[WORD_W-1:0];
  assign ht_row   = smudge ? work_src[ROW_W-1:0] : line_idx;
  assign ht_word  = ht_mem[ht_row];

  always_comb begin
    case (ht_rule)
      2'd0:    mixed = '1;
      2'd1:    mixed = ht_word;
      2'd2:    mixed = work_src;
      default: mixed = work_src & ht_word;
    endcase
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_rop
    assign result[b] = rop_code[{~mixed[b], ~dst_in[b]}];
  end

  assign dst_out    = (result & dst_mask) | (dst_in & ~dst_mask);
  assign dst_needed = !(&dst_mask) || (rop_code[0] != rop_code[1])
                                   || (rop_code[2] != rop_code[3]);

  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_load && !src_shift) |=> $stable(src_buf));

  assert_mask_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((dst_out ^ dst_in) & ~dst_mask) == '0);

  assert_rop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rop_code == 4'h0) |-> (dst_out == (dst_in & ~dst_mask)));

  assert_rop_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rop_code == 4'hF) |-> (dst_out == (dst_in | dst_mask)));

  assert_no_dst_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rop_code == 4'h3 && dst_mask == '1) |-> !dst_needed);

  assert_ht_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ht_we |=> (ht_addr != $past(ht_addr)) || (ht_rdata == $past(ht_wdata)));
endmodule

// File: tb/rop_word_path_bench.sv
module rop_word_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_load = 0, src_shift = 0, src_rtl = 0, smudge = 0, ht_we = 0;
  logic [15:0] src_word = 0, dst_in = 0, dst_mask = 0, ht_wdata = 0;
  logic [3:0]  skew = 0, rop_code = 0, line_idx = 0, ht_addr = 0;
  logic [1:0]  ht_rule = 0;
  logic [15:0] ht_rdata, dst_out;
  logic        dst_needed;

  logic [31:0] mbuf;
  logic [15:0] mmem [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rop_word_path u_rop_word_path (
    .clk(clk), .rst_n(rst_n), .src_load(src_load), .src_shift(src_shift),
    .src_rtl(src_rtl), .src_word(src_word), .skew(skew), .ht_rule(ht_rule),
    .rop_code(rop_code), .smudge(smudge), .line_idx(line_idx), .dst_in(dst_in),
    .dst_mask(dst_mask), .ht_we(ht_we), .ht_addr(ht_addr), .ht_wdata(ht_wdata),
    .ht_rdata(ht_rdata), .dst_out(dst_out), .dst_needed(dst_needed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_out();
    logic [31:0] sh;
    logic [15:0] w, h, m, r;
    sh = mbuf >> skew;
    w  = sh[15:0];
    h  = mmem[smudge ? w[3:0] : line_idx];
    case (ht_rule)
      2'd0: m = 16'hFFFF;
      2'd1: m = h;
      2'd2: m = w;
      default: m = w & h;
    endcase
    for (int b = 0; b < 16; b++) begin
      case ({m[b], dst_in[b]})
        2'b11: r[b] = rop_code[0];
        2'b10: r[b] = rop_code[1];
        2'b01: r[b] = rop_code[2];
        default: r[b] = rop_code[3];
      endcase
    end
    return (r & dst_mask) | (dst_in & ~dst_mask);
  endfunction

  function automatic logic exp_needed();
    return (dst_mask != 16'hFFFF) || (rop_code[0] != rop_code[1]) || (rop_code[2] != rop_code[3]);
  endfunction

  // Inputs already set after a falling edge; check, then take the rising edge.
  task automatic cycle(input string tag);
    #1;
    chk(tag, {16'h0, dst_out}, {16'h0, exp_out()});
    chk("R11", {31'h0, dst_needed}, {31'h0, exp_needed()});
    chk("R7", {16'h0, ht_rdata}, {16'h0, mmem[ht_addr]});
    @(posedge clk);
    if (src_load)
      mbuf = src_rtl ? {src_word, mbuf[31:16]} : {mbuf[15:0], src_word};
    else if (src_shift)
      mbuf = src_rtl ? {mbuf[31:16], mbuf[31:16]} : {mbuf[15:0], mbuf[15:0]};
    if (ht_we) mmem[ht_addr] = ht_wdata;
    @(negedge clk);
    src_load = 0; src_shift = 0; ht_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mbuf = 0;
    for (int i = 0; i < 16; i++) mmem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    ht_rule = 2; rop_code = 4'h3; dst_mask = 16'hFFFF; dst_in = 16'hBEEF;
    #1 chk("R1", {16'h0, dst_out}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      ht_addr = a[3:0];
      #1 chk("R1", {16'h0, ht_rdata}, 32'h0);
    end
    @(negedge clk);

    // R2: left-to-right loads
    src_load = 1; src_word = 16'h1234; cycle("R2");
    src_load = 1; src_word = 16'h5678; cycle("R2");
    cycle("R2");
    // R5: skew window
    skew = 4; cycle("R5");
    skew = 15; cycle("R5");
    skew = 0;
    // R3: right-to-left load
    src_rtl = 1; src_load = 1; src_word = 16'h9ABC; cycle("R3");
    skew = 8; cycle("R3");
    skew = 0; cycle("R3");
    // R4: suppressed read, both directions, and precedence
    src_rtl = 0; src_shift = 1; cycle("R4");
    skew = 12; cycle("R4");
    src_rtl = 1; src_load = 1; src_word = 16'h0F0F; cycle("R4");
    src_rtl = 1; src_shift = 1; cycle("R4");
    skew = 3; cycle("R4");
    src_load = 1; src_shift = 1; src_rtl = 0; src_word = 16'hC3C3; cycle("R4");
    cycle("R4");
    // R9: combine codes
    dst_in = 16'hF0F0; skew = 0;
    rop_code = 4'h0; cycle("R9");
    rop_code = 4'h6; cycle("R9");
    rop_code = 4'hF; cycle("R9");
    rop_code = 4'hC; cycle("R9");
    rop_code = 4'h1; cycle("R9");
    // R7: fill the pattern store
    for (int a = 0; a < 16; a++) begin
      ht_we = 1; ht_addr = a[3:0]; ht_wdata = 16'hA5A5 ^ (16'h1111 * a[15:0]);
      cycle("R7");
    end
    ht_addr = 4'd9; cycle("R7");
    // R12: same-cycle response to a combinational change
    rop_code = 4'h3; dst_mask = 16'h00FF; dst_in = 16'h1357; cycle("R12");
    dst_in = 16'hFFFF; cycle("R12");
    // R6 / R8: halftone rules and row selection
    dst_mask = 16'hFFFF; rop_code = 4'h3;
    ht_rule = 1; line_idx = 5; cycle("R8");
    line_idx = 14; cycle("R8");
    ht_rule = 0; cycle("R6");
    ht_rule = 3; cycle("R6");
    ht_rule = 1; smudge = 1; cycle("R8");
    src_load = 1; src_word = 16'h000B; cycle("R8");
    cycle("R8");
    smudge = 0;
    // R10: mask extremes
    ht_rule = 2; rop_code = 4'hA; dst_mask = 16'h0000; cycle("R10");
    dst_mask = 16'h00FF; cycle("R10");
    // R11: destination-needed flag
    rop_code = 4'h3; dst_mask = 16'hFFFF; cycle("R11");
    rop_code = 4'h5; cycle("R11");
    rop_code = 4'hC; dst_mask = 16'hFFFE; cycle("R11");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      src_load  = ($urandom % 2) == 0;
      src_shift = ($urandom % 5) == 0;
      src_rtl   = ($urandom % 3) == 0;
      src_word  = 16'($urandom);
      skew      = 4'($urandom);
      ht_rule   = 2'($urandom);
      rop_code  = 4'($urandom);
      smudge    = ($urandom % 4) == 0;
      line_idx  = 4'($urandom);
      dst_in    = 16'($urandom);
      case ($urandom % 4)
        0: dst_mask = 16'hFFFF;
        1: dst_mask = 16'h0000;
        default: dst_mask = 16'($urandom);
      endcase
      ht_we    = ($urandom % 5) == 0;
      ht_addr  = 4'($urandom);
      ht_wdata = 16'($urandom);
      cycle("R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule